// File: doc/BRIEF.md
# Table-Driven Graph Sequencer

This block is a controller that executes an algorithmic state machine stored as a table of vertices in an internal memory. Software or a neighbouring block fills the table through a single write port, one vertex per write. Each vertex is an operator, which carries a vector of microoperation bits and one successor, a conditional, which names one condition input and has two successors, or an End marker. Vertex 0 is the Begin vertex.

A start pulse makes the sequencer walk the graph from Begin. In every clock the operator it has reached drives its microoperation bits. In the same clock a combinational walker follows any conditional vertices that lead to the next operator, so two operators always run on back-to-back clocks, however many conditions lie between them. A conditional vertex whose selected exit points to itself is a waiting vertex. The sequencer parks there with all microoperations low and checks the condition again on every clock. Condition inputs may be wired to the microoperation outputs of other sequencers, which lets parallel processes wait for each other. If a walk runs into too many conditional vertices in one clock, the sequencer stops and raises a fault.

Top module: `graph_seq_top`

## Requirements
- R1: A table write with `tbl_we_i` high while the sequencer is idle stores one vertex at `tbl_addr_i`. The kind code is 0 for operator, 1 for conditional, and 2 or 3 for End. For a conditional, the condition index is in payload bits [3:0]. The successor for exit 1 (or after an operator) is on `tbl_succ1_i`, and the successor for exit 0 is on `tbl_succ0_i`. A write while `busy_o` is high leaves the table unchanged.
- R2: A start pulse while idle raises `busy_o` on the next clock. In that clock the sequencer sits at vertex 0 (Begin) and `uop_o` is 0 whatever Begin's payload holds. A start pulse while busy has no effect on the trace.
- R3: In each clock spent at an operator vertex other than Begin, `uop_o` equals that vertex's payload, and only for that one clock.
- R4: At a conditional vertex the walk takes the exit-1 successor when `cond_i[index]` is 1 and the exit-0 successor otherwise. Conditional vertices use no clock, so the operator reached next runs on the very next clock.
- R5: When the selected exit of a conditional vertex points to that same vertex, the sequencer waits there. During the wait `uop_o` is 0, `busy_o` stays 1, and the condition is evaluated again on every clock. It leaves on the clock after the condition changes.
- R6: On reaching an End vertex, `done_o` is 1 for exactly that clock with `uop_o` at 0, and `busy_o` is 0 from the next clock on.
- R7: One walk may pass through up to 8 conditional vertices. If a ninth conditional vertex would have to be crossed, `fault_o` rises on the next clock, `busy_o` falls at the same time, and `fault_o` holds until the next accepted start, which clears it.
- R8: While reset is asserted and after it, until a start, `uop_o`, `busy_o`, `done_o` and `fault_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin execution at vertex 0 when idle |
| cond_i | input | 16 | Condition inputs selected by conditional vertices |
| uop_o | output | 16 | Microoperation bits of the current operator |
| busy_o | output | 1 | High while a graph is executing |
| done_o | output | 1 | One-clock pulse at End |
| fault_o | output | 1 | Walk exceeded the per-clock conditional limit |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_addr_i | input | 6 | Vertex number to write |
| tbl_kind_i | input | 2 | Vertex kind code |
| tbl_payload_i | input | 16 | Microoperation bits or condition index |
| tbl_succ1_i | input | 6 | Successor after operator or on condition 1 |
| tbl_succ0_i | input | 6 | Successor on condition 0 |

## Verification
The hardest state to reach is the edge of the hop limit. A walk must cross exactly eight conditional vertices without trouble, and a ninth must trip the fault, all inside one clock. The stimulus gets there by rewriting the first operator's successor so that it points into a straight run of eight conditionals that ends in an operator, and then into a run one vertex longer. The run is the same in both cases, so the only difference between success and fault is the single extra hop. A waiting vertex is held for several clocks while a table write and a second start pulse are applied. A later run through the rewritten vertex then shows at the outputs that neither had any effect.

// File: rtl/graph_seq_pkg.sv
package graph_seq_pkg;

  typedef enum logic [1:0] {
    VK_OPER = 2'd0,
    VK_COND = 2'd1,
    VK_FIN  = 2'd2
  } vkind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_st_e;

  function automatic logic kind_is_fin(input logic [1:0] k);
    return k[1];
  endfunction

endpackage

// File: rtl/graph_seq_store.sv
module graph_seq_store #(
  parameter int DEPTH = 64,
  parameter int EW    = 30,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we_i,
  input  logic                       lock_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [EW-1:0]              data_i,
  output logic [DEPTH-1:0][EW-1:0]   mem_q
);

  logic wr_en;
  assign wr_en = we_i && !lock_i;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[addr_i] <= data_i;
    end
  end

  // R1: a write while locked leaves the addressed vertex untouched
  assert_locked_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && lock_i) |=> mem_q[$past(addr_i)] == $past(mem_q[addr_i]));

endmodule

// File: rtl/graph_seq_walker.sv
module graph_seq_walker
  import graph_seq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int UOP_W    = 16,
  parameter int COND_W   = 16,
  parameter int MAX_HOPS = 8,
  localparam int AW      = $clog2(DEPTH),
  localparam int CIW     = $clog2(COND_W),
  localparam int EW      = 2 + UOP_W + 2*AW,
  localparam int NSTG    = MAX_HOPS + 1,
  localparam int S0_LSB  = 0,
  localparam int S1_LSB  = AW,
  localparam int PL_LSB  = 2*AW,
  localparam int KD_LSB  = 2*AW + UOP_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DEPTH-1:0][EW-1:0]  mem_i,
  input  logic [COND_W-1:0]         cond_i,
  input  logic [AW-1:0]             from_i,
  output logic [AW-1:0]             dest_o,
  output logic                      park_o,
  output logic                      fault_o
);

  logic [AW-1:0] at_v   [NSTG+1];
  logic          live_v [NSTG+1];
  logic [NSTG-1:0] stop_v;
  logic [NSTG-1:0] park_v;

  assign at_v[0]   = from_i;
  assign live_v[0] = 1'b1;

  for (genvar i = 0; i < NSTG; i++) begin : g_hop
    logic [1:0]     kind;
    logic [CIW-1:0] cidx;
    logic [AW-1:0]  tgt;
    logic           is_cond;
    logic           selfw;

    assign kind    = mem_i[at_v[i]][KD_LSB +: 2];
    assign cidx    = mem_i[at_v[i]][PL_LSB +: CIW];
    assign is_cond = (kind == VK_COND);
    assign tgt     = cond_i[cidx] ? mem_i[at_v[i]][S1_LSB +: AW]
                                  : mem_i[at_v[i]][S0_LSB +: AW];
    assign at_v[i+1] = tgt;

    if (i == NSTG-1) begin : g_last
      assign selfw       = 1'b0;
      assign stop_v[i]   = live_v[i] && !is_cond;
      assign park_v[i]   = 1'b0;
      assign live_v[i+1] = live_v[i] && is_cond;
    end else begin : g_mid
      assign selfw       = is_cond && (tgt == at_v[i]);
      assign stop_v[i]   = live_v[i] && (!is_cond || selfw);
      assign park_v[i]   = live_v[i] && selfw;
      assign live_v[i+1] = live_v[i] && is_cond && !selfw;
    end
  end

  always_comb begin
    dest_o = '0;
    for (int i = 0; i < NSTG; i++) begin
      if (stop_v[i]) dest_o = dest_o | at_v[i];
    end
  end

  assign park_o  = |park_v;
  assign fault_o = live_v[NSTG];

  // R4: a walk ends in exactly one way: landing, parking or fault
  assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fault_o, |stop_v}) && (park_o -> !fault_o));

endmodule

// File: rtl/graph_seq_top.sv
module graph_seq_top
  import graph_seq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int UOP_W    = 16,
  parameter int COND_W   = 16,
  parameter int MAX_HOPS = 8,
  localparam int AW      = $clog2(DEPTH),
  localparam int EW      = 2 + UOP_W + 2*AW,
  localparam int S1_LSB  = AW,
  localparam int PL_LSB  = 2*AW,
  localparam int KD_LSB  = 2*AW + UOP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [COND_W-1:0] cond_i,
  output logic [UOP_W-1:0]  uop_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  input  logic              tbl_we_i,
  input  logic [AW-1:0]     tbl_addr_i,
  input  logic [1:0]        tbl_kind_i,
  input  logic [UOP_W-1:0]  tbl_payload_i,
  input  logic [AW-1:0]     tbl_succ1_i,
  input  logic [AW-1:0]     tbl_succ0_i
);

  logic [DEPTH-1:0][EW-1:0] mem_q;
  seq_st_e       st_q, st_d;
  logic [AW-1:0] pc_q, pc_d;
  logic          beg_q, beg_d;
  logic          flt_q, flt_d;
  logic          pc_en;

  logic [1:0]    cur_kind;
  logic          cur_fin;
  logic [AW-1:0] walk_from;
  logic [AW-1:0] walk_dest;
  logic          walk_park;
  logic          walk_fault;

  graph_seq_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (tbl_we_i),
    .lock_i (busy_o),
    .addr_i (tbl_addr_i),
    .data_i ({tbl_kind_i, tbl_payload_i, tbl_succ1_i, tbl_succ0_i}),
    .mem_q  (mem_q)
  );

  assign cur_kind  = mem_q[pc_q][KD_LSB +: 2];
  assign cur_fin   = kind_is_fin(cur_kind);
  assign walk_from = (cur_kind == VK_COND) ? pc_q : mem_q[pc_q][S1_LSB +: AW];

  graph_seq_walker #(
    .DEPTH(DEPTH), .UOP_W(UOP_W), .COND_W(COND_W), .MAX_HOPS(MAX_HOPS)
  ) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mem_i   (mem_q),
    .cond_i  (cond_i),
    .from_i  (walk_from),
    .dest_o  (walk_dest),
    .park_o  (walk_park),
    .fault_o (walk_fault)
  );

  // Next-state logic
  always_comb begin
    st_d  = st_q;
    pc_d  = pc_q;
    beg_d = beg_q;
    flt_d = flt_q;
    pc_en = 1'b0;
    if (st_q == ST_IDLE) begin
      if (start_i) begin
        st_d  = ST_RUN;
        pc_d  = '0;
        beg_d = 1'b1;
        flt_d = 1'b0;
        pc_en = 1'b1;
      end
    end else if (cur_fin) begin
      st_d = ST_IDLE;
    end else if (walk_fault) begin
      st_d  = ST_IDLE;
      flt_d = 1'b1;
    end else begin
      pc_d  = walk_dest;
      beg_d = 1'b0;
      pc_en = 1'b1;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      pc_q  <= '0;
      beg_q <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      flt_q <= flt_d;
      if (pc_en) begin
        pc_q  <= pc_d;
        beg_q <= beg_d;
      end
    end
  end

  assign busy_o  = (st_q == ST_RUN);
  assign done_o  = busy_o && cur_fin;
  assign fault_o = flt_q;
  assign uop_o   = (busy_o && cur_kind == VK_OPER && !beg_q)
                   ? mem_q[pc_q][PL_LSB +: UOP_W] : '0;

  // R8: nothing is driven while idle
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (uop_o == '0 && !done_o));

  // R2: the Begin clock drives no microoperations
  assert_begin_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> uop_o == '0);

  // R6: End is followed by idle
  assert_done_then_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  // R5: a parked walk yields a quiet busy clock
  assert_wait_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && walk_park) |=> (busy_o && uop_o == '0));

  // R7: a fault stops the sequencer
  assert_fault_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> !busy_o);

endmodule

// File: tb/sim_graph_seq_top.sv
`timescale 1ns/1ps
module sim_graph_seq_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [15:0] cond_i;
  logic [15:0] uop_o;
  logic        busy_o, done_o, fault_o;
  logic        tbl_we_i;
  logic [5:0]  tbl_addr_i;
  logic [1:0]  tbl_kind_i;
  logic [15:0] tbl_payload_i;
  logic [5:0]  tbl_succ1_i, tbl_succ0_i;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  localparam logic [1:0] OPR = 2'd0, CND = 2'd1, FIN = 2'd2;

  always #5 clk = ~clk;

  graph_seq_top u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cond_i(cond_i),
    .uop_o(uop_o), .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o),
    .tbl_we_i(tbl_we_i), .tbl_addr_i(tbl_addr_i), .tbl_kind_i(tbl_kind_i),
    .tbl_payload_i(tbl_payload_i), .tbl_succ1_i(tbl_succ1_i),
    .tbl_succ0_i(tbl_succ0_i)
  );

  task automatic chk(input logic [15:0] eu, input logic eb, input logic ed,
                     input logic ef, input string tag);
    n_chk++;
    if (uop_o !== eu || busy_o !== eb || done_o !== ed || fault_o !== ef) begin
      n_fail++;
      $display("FAIL %s: got uop=%h busy=%b done=%b fault=%b, expected uop=%h busy=%b done=%b fault=%b",
               tag, uop_o, busy_o, done_o, fault_o, eu, eb, ed, ef);
    end
  endtask

  task automatic step(input logic [15:0] eu, input logic eb, input logic ed,
                      input logic ef, input string tag);
    @(negedge clk);
    chk(eu, eb, ed, ef, tag);
  endtask

  task automatic ld(input int a, input logic [1:0] k, input logic [15:0] p,
                    input int s1, input int s0);
    @(negedge clk);
    tbl_we_i = 1'b1; tbl_addr_i = 6'(a); tbl_kind_i = k;
    tbl_payload_i = p; tbl_succ1_i = 6'(s1); tbl_succ0_i = 6'(s0);
    @(negedge clk);
    tbl_we_i = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; cond_i = '0; tbl_we_i = 1'b0;
    tbl_addr_i = '0; tbl_kind_i = '0; tbl_payload_i = '0;
    tbl_succ1_i = '0; tbl_succ0_i = '0;
    repeat (3) @(negedge clk);
    chk(16'h0, 1'b0, 1'b0, 1'b0, "R8 in reset");
    rst_n = 1'b1;
    step(16'h0, 1'b0, 1'b0, 1'b0, "R8 after reset");
  endtask

  task automatic t_load();
    ld(0, OPR, 16'hFFFF, 1, 1);
    ld(1, OPR, 16'h0003, 2, 2);
    ld(2, CND, 16'h0002, 2, 3);
    ld(3, CND, 16'h0000, 4, 7);
    ld(4, CND, 16'h0001, 5, 7);
    ld(5, CND, 16'h0003, 6, 7);
    ld(6, OPR, 16'h0100, 8, 8);
    ld(7, OPR, 16'h0200, 8, 8);
    ld(8, OPR, 16'h8000, 9, 9);
    ld(9, FIN, 16'h0000, 9, 9);
  endtask

  // Chain of three conditionals taken with all ones
  task automatic t_branch(input string tag);
    cond_i = 16'h000B;
    kick();
    chk(16'h0000, 1'b1, 1'b0, 1'b0, {"R2 begin quiet ", tag});
    step(16'h0003, 1'b1, 1'b0, 1'b0, {"R3 first op ", tag});
    step(16'h0100, 1'b1, 1'b0, 1'b0, {"R4 R1 chain zero cycles ", tag});
    step(16'h8000, 1'b1, 1'b0, 1'b0, {"R3 next op ", tag});
    step(16'h0000, 1'b1, 1'b1, 1'b0, {"R6 done pulse ", tag});
    step(16'h0000, 1'b0, 1'b0, 1'b0, {"R6 idle after ", tag});
  endtask

  task automatic t_wait();
    cond_i = 16'h0004;
    kick();
    chk(16'h0000, 1'b1, 1'b0, 1'b0, "R2 begin");
    step(16'h0003, 1'b1, 1'b0, 1'b0, "R3 op before wait");
    step(16'h0000, 1'b1, 1'b0, 1'b0, "R5 wait 1");
    tbl_we_i = 1'b1; tbl_addr_i = 6'd6; tbl_kind_i = OPR;
    tbl_payload_i = 16'hAAAA; tbl_succ1_i = 6'd8; tbl_succ0_i = 6'd8;
    start_i = 1'b1;
    step(16'h0000, 1'b1, 1'b0, 1'b0, "R5 R2 wait 2 with start");
    tbl_we_i = 1'b0; start_i = 1'b0;
    step(16'h0000, 1'b1, 1'b0, 1'b0, "R5 wait 3");
    cond_i = 16'h0000;
    step(16'h0200, 1'b1, 1'b0, 1'b0, "R5 R4 leave on exit 0");
    step(16'h8000, 1'b1, 1'b0, 1'b0, "R3 after wait");
    step(16'h0000, 1'b1, 1'b1, 1'b0, "R6 done");
    step(16'h0000, 1'b0, 1'b0, 1'b0, "R6 idle");
  endtask

  task automatic t_hops8();
    for (int k = 30; k < 38; k++) ld(k, CND, 16'h0006, k + 1, k + 1);
    ld(38, OPR, 16'h0040, 9, 9);
    ld(1, OPR, 16'h0003, 30, 30);
    kick();
    chk(16'h0000, 1'b1, 1'b0, 1'b0, "R2 begin");
    step(16'h0003, 1'b1, 1'b0, 1'b0, "R3 op");
    step(16'h0040, 1'b1, 1'b0, 1'b0, "R7 eight hops allowed");
    step(16'h0000, 1'b1, 1'b1, 1'b0, "R6 done");
    step(16'h0000, 1'b0, 1'b0, 1'b0, "R6 idle");
  endtask

  task automatic t_hops9();
    ld(29, CND, 16'h0006, 30, 30);
    ld(1, OPR, 16'h0003, 29, 29);
    kick();
    chk(16'h0000, 1'b1, 1'b0, 1'b0, "R2 begin");
    step(16'h0003, 1'b1, 1'b0, 1'b0, "R3 op");
    step(16'h0000, 1'b0, 1'b0, 1'b1, "R7 nine hops fault");
    step(16'h0000, 1'b0, 1'b0, 1'b1, "R7 fault held");
    ld(1, OPR, 16'h0003, 2, 2);
    cond_i = 16'h000B;
    kick();
    chk(16'h0000, 1'b1, 1'b0, 1'b0, "R7 start clears fault");
    step(16'h0003, 1'b1, 1'b0, 1'b0, "R3 op after fault");
    step(16'h0100, 1'b1, 1'b0, 1'b0, "R4 chain");
    step(16'h8000, 1'b1, 1'b0, 1'b0, "R3 op");
    step(16'h0000, 1'b1, 1'b1, 1'b0, "R6 done");
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got running, expected finished");
    finish_run();
  end

  initial begin
    t_reset();
    t_load();
    t_branch("run A");
    t_wait();
    t_branch("R1 locked write kept");
    t_hops8();
    t_hops9();
    finish_run();
  end

endmodule